// File: doc/BRIEF.md
# Raster Control-Symbol Sequencer for a Three-Lane TMDS Link

This block produces the complete raster for a DVI-style video link, one 10-bit symbol per lane per clock on three parallel lanes. Horizontal and vertical timing come from run-time inputs. Each axis has four lengths: the blanking ahead of sync, the sync pulse, the blanking after sync, and the visible span. Each sync signal also has a polarity input. During blanking the block emits TMDS control symbols. Lane 0 carries the horizontal and vertical sync levels. The other two lanes always carry the neutral control code.

During the visible span of a visible line, the block takes already-encoded pixel symbols from upstream through a ready/valid pair, one symbol triple per clock. When no triple is offered, it fills that slot with a DC-balanced symbol pair that draws a solid red line. A one-cycle request pulse marks the final blanking symbol before each visible span, so upstream logic knows when to have the next line ready.

The timing inputs are sampled into shadow registers during reset and again when the frame wraps. A change made in mid-frame therefore never tears the raster.

Top module: `raster_sym_seq`

## Requirements
- R1: Every line passes through four horizontal regions in the fixed order front blanking, sync, back blanking, visible. Region k lasts exactly the captured length k (each at least 1). The region counter restarts at zero on every region change. With lengths 16/96/48/640 a line is 800 clocks.
- R2: The vertical position advances once per line through the same four-region order and wraps to front blanking after the last visible line. With lengths 10/2/33/480 a frame is 525 lines.
- R3: While `rst` is high, all three lanes hold the index-00 control symbol, and `pix_ready` and `line_req` are low. The first symbol after reset belongs to line 0 of the vertical front blanking, at horizontal position 0. Each lane output is registered, so it shows the symbol for the state of the previous clock.
- R4: The lane-0 control symbol is picked by the index {vsync level, hsync level}: 00 gives 10'b1101010100, 01 gives 10'b0010101011, 10 gives 10'b0101010100, and 11 gives 10'b1010101011.
- R5: Lanes 1 and 2 emit the index-00 symbol in every cycle that is not a pixel cycle.
- R6: A sync level equals its polarity input while that sync is asserted (hsync in the horizontal sync region, vsync on lines in the vertical sync region) and equals the inverted polarity otherwise.
- R7: On lines outside the vertical visible region, the horizontal visible span still carries control symbols, with lane 0 using that line's vsync level and hsync deasserted.
- R8: In a pixel cycle with `pix_valid` low, the symbol depends on the parity of the offset within the visible span. At even offsets lanes 0 and 1 emit 10'h100 and lane 2 emits 10'h201. At odd offsets lanes 0 and 1 emit 10'h1FF and lane 2 emits 10'h2FE.
- R9: `line_req` is high for exactly one clock on every line, in the cycle in which the lanes show the last back-blanking symbol.
- R10: `pix_ready` is high exactly in the cycles whose state is in the visible region of a visible line. In such a cycle with `pix_valid` high, the lanes show `pix_l0`/`pix_l1`/`pix_l2` on the next clock.
- R11: The timing and polarity inputs take effect only at reset or at the start of the next frame. A mid-frame change leaves the rest of the current frame unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_h_front | input | 12 | Horizontal blanking before sync, in symbols |
| cfg_h_sync | input | 12 | Horizontal sync width |
| cfg_h_back | input | 12 | Horizontal blanking after sync |
| cfg_h_active | input | 12 | Visible symbols per line |
| cfg_v_front | input | 12 | Vertical blanking lines before sync |
| cfg_v_sync | input | 12 | Vertical sync lines |
| cfg_v_back | input | 12 | Vertical blanking lines after sync |
| cfg_v_active | input | 12 | Visible lines per frame |
| cfg_h_pol | input | 1 | Hsync level while asserted |
| cfg_v_pol | input | 1 | Vsync level while asserted |
| pix_valid | input | 1 | Pixel triple offered |
| pix_ready | output | 1 | Pixel triple consumed this cycle |
| pix_l0 | input | 10 | Encoded pixel symbol, lane 0 |
| pix_l1 | input | 10 | Encoded pixel symbol, lane 1 |
| pix_l2 | input | 10 | Encoded pixel symbol, lane 2 |
| tmds_l0 | output | 10 | Lane 0 symbol |
| tmds_l1 | output | 10 | Lane 1 symbol |
| tmds_l2 | output | 10 | Lane 2 symbol |
| line_req | output | 1 | Next-line preparation pulse |

## Verification
The hardest case to reach from the ports is a timing change that arrives in mid-frame. It has to be shown to alter nothing until the exact clock where the last visible symbol of the last visible line wraps. The bench changes the lengths and both polarities partway through a frame of a short raster. Its own position model reloads only at that wrap, and every following symbol is compared on all lanes. The full-size totals would take too long as one frame. So the 800-clock line is measured under a short vertical set, and the 525-line frame is counted between two vsync starts under a 5-clock line.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  localparam int SYM_W = 10;

  typedef enum logic [1:0] {
    RG_FRONT  = 2'd0,
    RG_SYNC   = 2'd1,
    RG_BACK   = 2'd2,
    RG_ACTIVE = 2'd3
  } region_e;

  // Fallback symbols for a balanced solid-red line
  localparam logic [SYM_W-1:0] FB01_EVEN = 10'h100;
  localparam logic [SYM_W-1:0] FB01_ODD  = 10'h1FF;
  localparam logic [SYM_W-1:0] FB2_EVEN  = 10'h201;
  localparam logic [SYM_W-1:0] FB2_ODD   = 10'h2FE;

  function automatic logic [SYM_W-1:0] ctrl_symbol(input logic [1:0] idx);
    case (idx)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction
endpackage

// File: rtl/rseq_region_ctr.sv
module rseq_region_ctr
  import rseq_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic [3:0][CW-1:0]  len,
  output region_e             region,
  output logic [CW-1:0]       cnt,
  output logic                last
);
  assign last = (cnt == len[region] - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      region <= RG_FRONT;
      cnt    <= '0;
    end else if (step) begin
      if (last) begin
        region <= region_e'(region + 2'd1);
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rseq_lane_fmt.sv
module rseq_lane_fmt
  import rseq_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sync_idx,
  input  logic             pix_cycle,
  input  logic             pix_valid,
  input  logic             phase,
  input  logic [SYM_W-1:0] pix_sym,
  output logic [SYM_W-1:0] sym
);
  localparam logic [SYM_W-1:0] FB_EVEN = (LANE == 2) ? FB2_EVEN : FB01_EVEN;
  localparam logic [SYM_W-1:0] FB_ODD  = (LANE == 2) ? FB2_ODD  : FB01_ODD;

  always_ff @(posedge clk) begin
    if (rst)
      sym <= ctrl_symbol(2'b00);
    else if (pix_cycle)
      sym <= pix_valid ? pix_sym : (phase ? FB_ODD : FB_EVEN);
    else
      sym <= ctrl_symbol(sync_idx);
  end
endmodule

// File: rtl/raster_sym_seq.sv
module raster_sym_seq
  import rseq_pkg::*;
#(
  parameter int CW = 12,
  parameter int NLANES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cfg_h_front,
  input  logic [CW-1:0]     cfg_h_sync,
  input  logic [CW-1:0]     cfg_h_back,
  input  logic [CW-1:0]     cfg_h_active,
  input  logic [CW-1:0]     cfg_v_front,
  input  logic [CW-1:0]     cfg_v_sync,
  input  logic [CW-1:0]     cfg_v_back,
  input  logic [CW-1:0]     cfg_v_active,
  input  logic              cfg_h_pol,
  input  logic              cfg_v_pol,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [SYM_W-1:0]  pix_l0,
  input  logic [SYM_W-1:0]  pix_l1,
  input  logic [SYM_W-1:0]  pix_l2,
  output logic [SYM_W-1:0]  tmds_l0,
  output logic [SYM_W-1:0]  tmds_l1,
  output logic [SYM_W-1:0]  tmds_l2,
  output logic              line_req
);
  logic [3:0][CW-1:0] h_len_q, v_len_q;
  logic               h_pol_q, v_pol_q;

  region_e            h_region, v_region;
  logic [CW-1:0]      h_cnt, v_cnt;
  logic               h_last, v_last;
  logic               h_wrap, frame_wrap;
  logic               pix_cycle;
  logic               hs_lvl, vs_lvl;

  logic [NLANES-1:0][SYM_W-1:0] pix_arr, lane_arr;

  assign h_wrap     = h_last && (h_region == RG_ACTIVE);
  assign frame_wrap = h_wrap && v_last && (v_region == RG_ACTIVE);

  // Shadow timing: loaded in reset and at the frame wrap only
  always_ff @(posedge clk) begin
    if (rst || frame_wrap) begin
      h_len_q <= {cfg_h_active, cfg_h_back, cfg_h_sync, cfg_h_front};
      v_len_q <= {cfg_v_active, cfg_v_back, cfg_v_sync, cfg_v_front};
      h_pol_q <= cfg_h_pol;
      v_pol_q <= cfg_v_pol;
    end
  end

  rseq_region_ctr #(.CW(CW)) u_hctr (
    .clk(clk), .rst(rst), .step(1'b1), .len(h_len_q),
    .region(h_region), .cnt(h_cnt), .last(h_last)
  );

  rseq_region_ctr #(.CW(CW)) u_vctr (
    .clk(clk), .rst(rst), .step(h_wrap), .len(v_len_q),
    .region(v_region), .cnt(v_cnt), .last(v_last)
  );

  assign pix_cycle = (h_region == RG_ACTIVE) && (v_region == RG_ACTIVE);
  assign pix_ready = pix_cycle;
  assign hs_lvl    = (h_region == RG_SYNC) ? h_pol_q : ~h_pol_q;
  assign vs_lvl    = (v_region == RG_SYNC) ? v_pol_q : ~v_pol_q;

  always_ff @(posedge clk) begin
    if (rst) line_req <= 1'b0;
    else     line_req <= (h_region == RG_BACK) && h_last;
  end

  assign pix_arr = {pix_l2, pix_l1, pix_l0};

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [1:0] idx;
    if (i == 0) begin : g_sync
      assign idx = {vs_lvl, hs_lvl};
    end else begin : g_plain
      assign idx = 2'b00;
    end
    rseq_lane_fmt #(.LANE(i)) u_fmt (
      .clk(clk), .rst(rst), .sync_idx(idx), .pix_cycle(pix_cycle),
      .pix_valid(pix_valid), .phase(h_cnt[0]), .pix_sym(pix_arr[i]),
      .sym(lane_arr[i])
    );
  end

  assign tmds_l0 = lane_arr[0];
  assign tmds_l1 = lane_arr[1];
  assign tmds_l2 = lane_arr[2];
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    h_region,
  input logic [1:0]    v_region,
  input logic [CW-1:0] h_cnt,
  input logic [CW-1:0] v_cnt,
  input logic          pix_ready,
  input logic          pix_valid,
  input logic [9:0]    pix_l0,
  input logic [9:0]    tmds_l0,
  input logic [9:0]    tmds_l1,
  input logic [9:0]    tmds_l2,
  input logic          line_req
);
  AST_H_REGION_ORDER: assert property (@(posedge clk) disable iff (rst)
    (h_region != $past(h_region)) |-> (h_region == $past(h_region) + 2'd1)); // R1
  AST_H_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (h_region != $past(h_region)) |-> (h_cnt == '0)); // R1
  AST_V_REGION_ORDER: assert property (@(posedge clk) disable iff (rst)
    (v_region != $past(v_region)) |-> (v_region == $past(v_region) + 2'd1)); // R2
  AST_V_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (v_region != $past(v_region)) |-> (v_cnt == '0)); // R2
  AST_SIDE_LANES_CTRL: assert property (@(posedge clk) disable iff (rst)
    !$past(pix_ready) |-> (tmds_l1 == 10'b1101010100 && tmds_l2 == 10'b1101010100)); // R5
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_req |=> !line_req); // R9
  AST_REQ_BEFORE_PIX: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_ready) |-> line_req); // R9
  AST_PIX_PASS: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && pix_valid) |=> (tmds_l0 == $past(pix_l0))); // R10
endmodule

bind raster_sym_seq rseq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .h_region(h_region), .v_region(v_region),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .pix_ready(pix_ready), .pix_valid(pix_valid),
  .pix_l0(pix_l0), .tmds_l0(tmds_l0), .tmds_l1(tmds_l1), .tmds_l2(tmds_l2),
  .line_req(line_req)
);

// File: tb/tb_raster_sym_seq.sv
module tb_raster_sym_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst;
  logic [11:0] hf, hs, hb, ha, vf, vs, vb, va;
  logic        hpol, vpol, pix_valid, pix_ready, line_req;
  logic [9:0]  p0, p1, p2, t0, t1, t2;

  raster_sym_seq dut (
    .clk(clk), .rst(rst),
    .cfg_h_front(hf), .cfg_h_sync(hs), .cfg_h_back(hb), .cfg_h_active(ha),
    .cfg_v_front(vf), .cfg_v_sync(vs), .cfg_v_back(vb), .cfg_v_active(va),
    .cfg_h_pol(hpol), .cfg_v_pol(vpol),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_l0(p0), .pix_l1(p1), .pix_l2(p2),
    .tmds_l0(t0), .tmds_l1(t1), .tmds_l2(t2), .line_req(line_req)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  // bench position model and its captured timing
  int hp, ln;
  int m_hf, m_hs, m_hb, m_ha, m_vf, m_vs, m_vb, m_va;
  bit m_hpol, m_vpol, reloaded;
  int last_req_cyc, req_interval, req_count;

  function automatic logic [9:0] csym(bit v, bit h);
    case ({v, h})
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic int rgn(int p, int a, int b, int c);
    if (p < a) return 0;
    if (p < a + b) return 1;
    if (p < a + b + c) return 2;
    return 3;
  endfunction

  task automatic check(string tag, logic [9:0] got, logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s%s: cycle %0d got %h expected %h", tag, reloaded ? "/R11" : "", cyc, got, exp);
    end
  endtask

  task automatic capture_model();
    m_hf = int'(hf); m_hs = int'(hs); m_hb = int'(hb); m_ha = int'(ha);
    m_vf = int'(vf); m_vs = int'(vs); m_vb = int'(vb); m_va = int'(va);
    m_hpol = hpol; m_vpol = vpol;
  endtask

  // one clock: compare lanes for the model position, then advance it
  task automatic step();
    int hr, vr, htot, vtot, off;
    bit pixc, lastf, hsl, vsl;
    logic [9:0] e0, e1, e2;
    @(posedge clk); @(negedge clk);
    cyc++;
    htot = m_hf + m_hs + m_hb + m_ha;
    vtot = m_vf + m_vs + m_vb + m_va;
    hr = rgn(hp, m_hf, m_hs, m_hb);
    vr = rgn(ln, m_vf, m_vs, m_vb);
    pixc = (hr == 3) && (vr == 3);
    if (pixc) begin
      off = hp - (m_hf + m_hs + m_hb);
      if (pix_valid) begin
        check("R10 lane0 pixel", t0, p0);
        check("R10 lane1 pixel", t1, p1);
        check("R10 lane2 pixel", t2, p2);
      end else begin
        e0 = off[0] ? 10'h1FF : 10'h100;
        e2 = off[0] ? 10'h2FE : 10'h201;
        check("R8 lane0 fallback", t0, e0);
        check("R8 lane1 fallback", t1, e0);
        check("R8 lane2 fallback", t2, e2);
      end
    end else begin
      hsl = (hr == 1) ? m_hpol : ~m_hpol;
      vsl = (vr == 1) ? m_vpol : ~m_vpol;
      e1 = csym(1'b0, 1'b0);
      if (hr == 1 || vr == 1) check("R6 lane0 sync", t0, csym(vsl, hsl));
      else if (hr == 3)       check("R7 lane0 blank line span", t0, csym(vsl, hsl));
      else                    check("R4 lane0 ctrl", t0, csym(vsl, hsl));
      check("R5 lane1 ctrl", t1, e1);
      check("R5 lane2 ctrl", t2, e1);
    end
    check("R9 line_req", {9'd0, line_req}, {9'd0, (hp == m_hf + m_hs + m_hb - 1)});
    if (line_req) begin
      req_count++;
      if (last_req_cyc >= 0) req_interval = cyc - last_req_cyc;
      last_req_cyc = cyc;
    end
    lastf = (hp == htot - 1) && (ln == vtot - 1);
    hp++;
    if (hp == htot) begin hp = 0; ln++; if (ln == vtot) ln = 0; end
    if (lastf) begin capture_model(); reloaded = 1'b0; end
    hr = rgn(hp, m_hf, m_hs, m_hb);
    vr = rgn(ln, m_vf, m_vs, m_vb);
    check("R10 pix_ready", {9'd0, pix_ready}, {9'd0, (hr == 3 && vr == 3)});
  endtask

  task automatic drive_pix(int pct);
    pix_valid = (($urandom % 100) < pct);
    p0 = 10'($urandom); p1 = 10'($urandom); p2 = 10'($urandom);
  endtask

  task automatic set_cfg(int a, int b, int c, int d, int e, int f, int g, int h, bit xp, bit yp);
    hf = 12'(a); hs = 12'(b); hb = 12'(c); ha = 12'(d);
    vf = 12'(e); vs = 12'(f); vb = 12'(g); va = 12'(h);
    hpol = xp; vpol = yp;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 reset lane0", t0, csym(1'b0, 1'b0));
    check("R3 reset lane1", t1, csym(1'b0, 1'b0));
    check("R3 reset lane2", t2, csym(1'b0, 1'b0));
    check("R3 reset pix_ready", {9'd0, pix_ready}, 10'd0);
    check("R3 reset line_req", {9'd0, line_req}, 10'd0);
    capture_model();
    hp = 0; ln = 0; reloaded = 1'b0;
    last_req_cyc = -1; req_interval = 0; req_count = 0;
    rst = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    bit prev_vs, now_vs;
    int vs_edges;
    seed = $urandom(32'd2024);
    p0 = '0; p1 = '0; p2 = '0;
    // Phase 1: short raster, random pixel availability (R1..R10)
    set_cfg(3, 2, 4, 8, 2, 1, 2, 4, 1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < 153 * 2 + 70; i++) begin step(); drive_pix(50); end
    // Phase 2: mid-frame change of all timing and both polarities (R11)
    set_cfg(2, 3, 2, 6, 1, 2, 1, 3, 1'b0, 1'b1);
    reloaded = 1'b1;
    for (int i = 0; i < 600; i++) begin step(); drive_pix(50); end
    // Phase 3: all-missing then all-present pixels (R8, R10)
    for (int i = 0; i < 200; i++) begin step(); drive_pix(0); end
    for (int i = 0; i < 200; i++) begin step(); drive_pix(100); end
    // Phase 4: 640-wide horizontal set, 800 clocks per line (R1)
    set_cfg(16, 96, 48, 640, 1, 1, 1, 2, 1'b0, 1'b0);
    do_reset();
    for (int i = 0; i < 2000 && req_count < 3; i++) begin step(); drive_pix(70); end
    checks++;
    if (req_interval != 800) begin
      fails++;
      $display("FAIL R1 line length: got %0d expected %0d", req_interval, 800);
    end
    // Phase 5: 480-line vertical set, 525 lines per frame (R2)
    set_cfg(1, 1, 1, 2, 10, 2, 33, 480, 1'b0, 1'b0);
    do_reset();
    pix_valid = 1'b0;
    prev_vs = 1'b0; vs_edges = 0;
    for (int i = 0; i < 6000 && vs_edges < 2; i++) begin
      step();
      now_vs = (t0 == csym(1'b0, 1'b0)) || (t0 == csym(1'b0, 1'b1));
      if (now_vs && !prev_vs) begin
        vs_edges++;
        if (vs_edges == 1) req_count = 0;
      end
      prev_vs = now_vs;
    end
    checks++;
    if (vs_edges != 2 || req_count != 525) begin
      fails++;
      $display("FAIL R2 frame lines: got %0d expected %0d", req_count, 525);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule